// File: doc/BRIEF.md
# Master Byte FIFO and Interrupt Unit

This unit sits between a host register port and a serial bus transfer engine. It keeps two byte queues of 128 entries each. The host fills the transmit queue and the engine drains it. The engine fills the receive queue and the host drains it. A control register lets software empty both queues at once and set a receive high-water mark. A count register reports how many received bytes are waiting, so software can drain a whole batch with no polling between bytes.

Engine events and queue levels feed a sticky status register. Software clears it by writing ones. An enable register selects which status bits raise the single level-sensitive interrupt line. The engine is not part of this unit. It is represented by push and pop strobes on the queues and by one-cycle event pulses.

Host register map (word index on `host_addr`): 0 transmit data (write pushes `wdata[7:0]`, reads 0), 1 receive data (read pops), 2 queue control, 3 receive count, 4 interrupt enable, 5 interrupt status.

Top module: `mfi_unit`

## Requirements
- R1: A host write to index 0 pushes `wdata[7:0]` onto the transmit queue. `eng_tx_data` shows the oldest byte, and `eng_tx_pop` removes it. The bytes come out in the order they were written. With the queue empty, `eng_tx_data` is 0.
- R2: An `eng_rx_push` stores `eng_rx_data`. A host read of index 1 returns the oldest byte in that same cycle and removes it. A read of an empty queue returns 0.
- R3: Each queue holds 128 bytes. A push to a full queue is dropped. Status bit 4 is set on every cycle that follows a dropped push, or that follows a cycle in which either queue held 128 bytes.
- R4: Reading index 3 returns the receive queue occupancy in bits 7:0, from 0 to 128. The upper bits read as 0.
- R5: Queue control (index 2) holds the high threshold in bits 15:8 and the low threshold in bits 7:0, and reads back as `{hi,lo}`. A write with bit 16 set empties both queues in one cycle and leaves both thresholds unchanged. That write also ignores pushes and pops in the same cycle. A write with bit 16 clear loads both thresholds.
- R6: When the high threshold is nonzero and the receive count is at or above it, status bit 2 is set one cycle later. Thresholds up to 128 are honoured.
- R7: Status bit 2 has a partner for the transmit queue: status bit 3 is set one cycle after any cycle in which the transmit queue is empty.
- R8: Event pulses set sticky status bits on the next edge: address NACK at bit 25, address acknowledged at bit 13, transfer done at bit 12, arbitration lost at bit 11, bus error at bit 0. A set bit stays set until it is cleared.
- R9: A write to index 5 clears each status bit written as 1. If a set condition arrives in the same cycle, the bit stays 1.
- R10: Index 4 stores the enables for the defined status bits only. `irq` is high exactly while some status bit and its enable are both 1. Writing 0 to the enables drives `irq` low from the next cycle.
- R11: After reset both queues are empty, and status, enables, thresholds and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 3 | Register word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the strobe cycle |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte, 0 when empty |
| eng_tx_empty | output | 1 | Transmit queue empty |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_full | output | 1 | Receive queue full |
| ev_addr_nack | input | 1 | Address not acknowledged pulse |
| ev_addr_ack | input | 1 | Address acknowledged pulse |
| ev_xfer_done | input | 1 | Transfer complete pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_bus_err | input | 1 | Bus error pulse |
| irq | output | 1 | Level interrupt request |

## Verification
Read data and the transmit head are combinational, so the bench compares them 1 ns after it drives inputs, before the edge that pops. Event bits, clears, enables and `irq` change at the first edge after the stimulus, so the bench checks them after the following falling edge. Level-derived bits (2, 3 and 4) are one register further away. They rest on counts that were registered at the previous edge. The bench model therefore computes them from the occupancy before the update, and directed reads of these bits wait one idle cycle after the last push.

// File: rtl/mfi_pkg.sv
package mfi_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_TXDATA  = 3'd0,
        A_RXDATA  = 3'd1,
        A_QCTL    = 3'd2,
        A_RXCOUNT = 3'd3,
        A_IRQEN   = 3'd4,
        A_IRQSTAT = 3'd5
    } reg_addr_e;

    // status / enable bit positions (decoded by software)
    localparam int B_NACK  = 25;
    localparam int B_AACK  = 13;
    localparam int B_DONE  = 12;
    localparam int B_ARB   = 11;
    localparam int B_FULL  = 4;
    localparam int B_EMPTY = 3;
    localparam int B_HIGH  = 2;
    localparam int B_BERR  = 0;

    // queue control fields
    localparam int QCTL_FLUSH = 16;
    localparam int QCTL_HI_LSB = 8;
    localparam int QCTL_LO_LSB = 0;

    localparam logic [REG_W-1:0] IRQ_MASK =
        (32'd1 << B_NACK) | (32'd1 << B_AACK) | (32'd1 << B_DONE) |
        (32'd1 << B_ARB)  | (32'd1 << B_FULL) | (32'd1 << B_EMPTY) |
        (32'd1 << B_HIGH) | (32'd1 << B_BERR);
endpackage

// File: rtl/mfi_byte_fifo.sv
module mfi_byte_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH-1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        push_ok = push && !clr && (st_q.cnt != FULL_CNT);
        pop_ok  = pop  && !clr && (st_q.cnt != '0);
        dropped = push && !clr && (st_q.cnt == FULL_CNT);
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = (st_q.wp == LAST_PTR) ? '0 : st_q.wp + AW'(1);
            if (pop_ok)  st_d.rp = (st_q.rp == LAST_PTR) ? '0 : st_q.rp + AW'(1);
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= push_data;
    end

    assign head  = (st_q.cnt != '0) ? mem_q[st_q.rp] : '0;
    assign count = st_q.cnt;

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);
    // R5
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    // R3
    drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dropped && !pop) |=> (count == FULL_CNT));
endmodule

// File: rtl/mfi_irq_status.sv
module mfi_irq_status #(
    parameter int               NB   = 32,
    parameter logic [NB-1:0]    MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_vec,
    input  logic          clr_we,
    input  logic [NB-1:0] clr_vec,
    input  logic          en_we,
    input  logic [NB-1:0] en_wdata,
    output logic [NB-1:0] stat,
    output logic [NB-1:0] en,
    output logic          irq
);
    typedef struct packed {
        logic [NB-1:0] stat;
        logic [NB-1:0] en;
    } irq_st_t;

    irq_st_t st_q, st_d;
    logic [NB-1:0] clr_eff;

    always_comb begin
        clr_eff     = clr_we ? clr_vec : '0;
        st_d        = st_q;
        st_d.stat   = ((st_q.stat & ~clr_eff) | set_vec) & MASK;
        if (en_we) st_d.en = en_wdata & MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
    assign en   = st_q.en;
    assign irq  = |(st_q.stat & st_q.en);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((stat & $past(set_vec & MASK)) == $past(set_vec & MASK)));
    // R9
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((stat & $past(clr_vec & ~set_vec)) == '0));
    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/mfi_unit.sv
module mfi_unit
    import mfi_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int TW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [REG_W-1:0]     host_wdata,
    output logic [REG_W-1:0]     host_rdata,
    input  logic                 eng_tx_pop,
    output logic [7:0]           eng_tx_data,
    output logic                 eng_tx_empty,
    input  logic                 eng_rx_push,
    input  logic [7:0]           eng_rx_data,
    output logic                 eng_rx_full,
    input  logic                 ev_addr_nack,
    input  logic                 ev_addr_ack,
    input  logic                 ev_xfer_done,
    input  logic                 ev_arb_lost,
    input  logic                 ev_bus_err,
    output logic                 irq
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [TW-1:0] hi;
        logic [TW-1:0] lo;
    } qctl_t;

    qctl_t ctl_q, ctl_d;

    logic          wr_tx, rd_rx, wr_ctl, wr_en, wr_stat, flush;
    logic [7:0]    rx_head;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_drop, rx_drop;
    logic          high_lvl;
    logic [REG_W-1:0] set_vec, stat, en;

    // register decode
    always_comb begin
        wr_tx   = host_wr && (host_addr == A_TXDATA);
        rd_rx   = host_rd && (host_addr == A_RXDATA);
        wr_ctl  = host_wr && (host_addr == A_QCTL);
        wr_en   = host_wr && (host_addr == A_IRQEN);
        wr_stat = host_wr && (host_addr == A_IRQSTAT);
        flush   = wr_ctl && host_wdata[QCTL_FLUSH];
    end

    // threshold register
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl && !host_wdata[QCTL_FLUSH]) begin
            ctl_d.hi = host_wdata[QCTL_HI_LSB +: TW];
            ctl_d.lo = host_wdata[QCTL_LO_LSB +: TW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    mfi_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .push      (wr_tx),
        .push_data (host_wdata[7:0]),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .count     (tx_cnt),
        .dropped   (tx_drop)
    );

    mfi_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rd_rx),
        .head      (rx_head),
        .count     (rx_cnt),
        .dropped   (rx_drop)
    );

    // event gathering
    always_comb begin
        high_lvl = (ctl_q.hi != '0) && (32'(rx_cnt) >= 32'(ctl_q.hi));
        set_vec = '0;
        set_vec[B_NACK]  = ev_addr_nack;
        set_vec[B_AACK]  = ev_addr_ack;
        set_vec[B_DONE]  = ev_xfer_done;
        set_vec[B_ARB]   = ev_arb_lost;
        set_vec[B_BERR]  = ev_bus_err;
        set_vec[B_EMPTY] = (tx_cnt == '0);
        set_vec[B_HIGH]  = high_lvl;
        set_vec[B_FULL]  = tx_drop || rx_drop ||
                           (tx_cnt == FULL_CNT) || (rx_cnt == FULL_CNT);
    end

    mfi_irq_status #(.NB(REG_W), .MASK(IRQ_MASK)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (wr_stat),
        .clr_vec  (host_wdata),
        .en_we    (wr_en),
        .en_wdata (host_wdata),
        .stat     (stat),
        .en       (en),
        .irq      (irq)
    );

    // read mux
    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            case (reg_addr_e'(host_addr))
                A_RXDATA:  host_rdata = 32'(rx_head);
                A_QCTL:    host_rdata = (32'(ctl_q.hi) << QCTL_HI_LSB) |
                                        (32'(ctl_q.lo) << QCTL_LO_LSB);
                A_RXCOUNT: host_rdata = 32'(rx_cnt);
                A_IRQEN:   host_rdata = en;
                A_IRQSTAT: host_rdata = stat;
                default:   host_rdata = '0;
            endcase
        end
    end

    assign eng_tx_empty = (tx_cnt == '0);
    assign eng_rx_full  = (rx_cnt == FULL_CNT);

    // R10
    en_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && host_wdata == '0) |=> !irq);
    // R6
    high_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_lvl |=> stat[B_HIGH]);
    // R5
    flush_keeps_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ctl_q == $past(ctl_q)));
    // R8
    event_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_err |=> stat[B_BERR]);
endmodule

// File: tb/mfi_unit_tb.sv
module mfi_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        txpop = 1'b0;
    logic [7:0]  txdata;
    logic        txempty;
    logic        rxpush = 1'b0;
    logic [7:0]  rxd = '0;
    logic        rxfull;
    logic [4:0]  ev = '0; // {nack, aack, done, arb, berr}
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [31:0] MASK = 32'h0200_381D;

    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    logic [31:0] mstat = '0, men = '0;
    logic [7:0]  mhi = '0, mlo = '0;
    logic [31:0] last_rd;

    always #4 clk = ~clk; // 125 MHz

    mfi_unit u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(wr), .host_rd(rd), .host_addr(addr),
        .host_wdata(wdata), .host_rdata(rdata), .eng_tx_pop(txpop),
        .eng_tx_data(txdata), .eng_tx_empty(txempty), .eng_rx_push(rxpush),
        .eng_rx_data(rxd), .eng_rx_full(rxfull), .ev_addr_nack(ev[4]),
        .ev_addr_ack(ev[3]), .ev_xfer_done(ev[2]), .ev_arb_lost(ev[1]),
        .ev_bus_err(ev[0]), .irq(irq)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd1: return (rxq.size() == 0) ? 32'd0 : 32'(rxq[0]);
            3'd2: return {16'd0, mhi, mlo};
            3'd3: return 32'(rxq.size());
            3'd4: return men;
            3'd5: return mstat;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] a);
        case (a)
            3'd1: return "R2";
            3'd2: return "R5";
            3'd3: return "R4";
            3'd4: return "R10";
            3'd5: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic model_update();
        logic [31:0] set, clr;
        int tn, rn;
        logic flush;
        tn = txq.size();
        rn = rxq.size();
        set = '0;
        if (ev[4]) set[25] = 1'b1;
        if (ev[3]) set[13] = 1'b1;
        if (ev[2]) set[12] = 1'b1;
        if (ev[1]) set[11] = 1'b1;
        if (ev[0]) set[0]  = 1'b1;
        if (tn == 0) set[3] = 1'b1;
        if (mhi != 0 && rn >= int'(mhi)) set[2] = 1'b1;
        if (tn == 128 || rn == 128) set[4] = 1'b1;
        flush = wr && addr == 3'd2 && wdata[16];
        clr = (wr && addr == 3'd5) ? wdata : 32'd0;
        if (flush) begin
            txq.delete();
            rxq.delete();
        end else begin
            if (txpop && tn > 0) void'(txq.pop_front());
            if (wr && addr == 3'd0) begin
                if (tn < 128) txq.push_back(wdata[7:0]);
                else set[4] = 1'b1;
            end
            if (rd && addr == 3'd1 && rn > 0) void'(rxq.pop_front());
            if (rxpush) begin
                if (rn < 128) rxq.push_back(rxd);
                else set[4] = 1'b1;
            end
        end
        mstat = ((mstat & ~clr) | set) & MASK;
        if (wr && addr == 3'd4) men = wdata & MASK;
        if (wr && addr == 3'd2 && !wdata[16]) begin
            mhi = wdata[15:8];
            mlo = wdata[7:0];
        end
    endtask

    // inputs already driven after a falling edge; check, clock, check irq
    task automatic step();
        #1;
        if (rd) begin
            last_rd = rdata;
            chk(rdata, exp_read(addr), req_of(addr));
        end
        if (txpop) chk(32'(txdata), (txq.size() == 0) ? 32'd0 : 32'(txq[0]), "R1");
        model_update();
        @(posedge clk);
        @(negedge clk);
        chk(32'(irq), 32'(|(mstat & men)), "R10");
        wr = 0; rd = 0; txpop = 0; rxpush = 0; ev = '0; addr = '0; wdata = '0;
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
        wr = 1; addr = a; wdata = d; step();
    endtask

    task automatic hread(input logic [2:0] a);
        rd = 1; addr = a; step();
    endtask

    task automatic idle();
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL all: watchdog expired, got hang expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R11: reset state while held in reset
        repeat (3) @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            rd = 1; addr = 3'(a); #1;
            chk(rdata, 32'd0, "R11");
        end
        chk(32'(irq), 32'd0, "R11");
        chk(32'(txempty), 32'd1, "R11");
        rd = 0; addr = '0;
        @(negedge clk);
        rst_n = 1;

        // R7: empty transmit queue raises bit 3
        idle();
        hread(3'd5);
        chk(32'(last_rd[3]), 32'd1, "R7");

        // R1: order and empty head
        hwrite(3'd0, 32'hA1);
        hwrite(3'd0, 32'hB2);
        hwrite(3'd0, 32'hC3);
        #1 chk(32'(txdata), 32'hA1, "R1");
        for (int i = 0; i < 4; i++) begin txpop = 1; step(); end
        #1 chk(32'(txdata), 32'h0, "R1");

        // R3: overfill transmit queue
        hwrite(3'd5, 32'hFFFF_FFFF);
        for (int i = 0; i < 129; i++) hwrite(3'd0, 32'(i));
        hread(3'd5);
        chk(32'(last_rd[4]), 32'd1, "R3");
        for (int i = 0; i < 128; i++) begin txpop = 1; step(); end
        #1 chk(32'(txempty), 32'd1, "R3");

        // R6 / R4: high mark at full depth
        hwrite(3'd2, 32'h0000_8005);
        for (int i = 0; i < 127; i++) begin rxpush = 1; rxd = 8'(i + 7); step(); end
        hwrite(3'd5, 32'hFFFF_FFFF);
        hread(3'd5);
        chk(32'(last_rd[2]), 32'd0, "R6");
        rxpush = 1; rxd = 8'h5A; step();
        idle();
        hread(3'd5);
        chk(32'(last_rd[2]), 32'd1, "R6");
        hread(3'd3);
        chk(last_rd, 32'd128, "R4");
        rxpush = 1; rxd = 8'hEE; step();
        hread(3'd5);
        chk(32'(last_rd[4]), 32'd1, "R3");

        // R5: flush keeps thresholds
        hwrite(3'd2, 32'h0001_0000);
        hread(3'd3);
        chk(last_rd, 32'd0, "R5");
        hread(3'd2);
        chk(last_rd, 32'h0000_8005, "R5");
        hread(3'd1);
        chk(last_rd, 32'd0, "R2");

        // R8 / R9 / R10
        hwrite(3'd4, 32'hFFFF_FFFF);
        ev = 5'b00010; wr = 1; addr = 3'd5; wdata = 32'h0000_0800; step();
        hread(3'd5);
        chk(32'(last_rd[11]), 32'd1, "R9");
        hwrite(3'd5, 32'h0000_0800);
        hread(3'd5);
        chk(32'(last_rd[11]), 32'd0, "R9");
        ev = 5'b00001; step();
        repeat (3) idle();
        hread(3'd5);
        chk(32'(last_rd[0]), 32'd1, "R8");
        chk(32'(irq), 32'd1, "R10");
        hwrite(3'd4, 32'd0);
        chk(32'(irq), 32'd0, "R10");

        // constrained random traffic
        for (int n = 0; n < 6000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 30) begin wr = 1; addr = 3'd0; wdata = $urandom(); end
            else if (r < 55) begin rd = 1; addr = 3'd1; end
            else if (r < 62) begin wr = 1; addr = 3'd5; wdata = $urandom(); end
            else if (r < 67) begin wr = 1; addr = 3'd4; wdata = $urandom(); end
            else if (r < 71) begin
                wr = 1; addr = 3'd2;
                wdata = {15'd0, ($urandom_range(0, 9) == 0),
                         8'($urandom_range(0, 128)), 8'($urandom())};
            end else if (r < 80) begin rd = 1; addr = 3'($urandom_range(2, 5)); end
            txpop  = ($urandom_range(0, 99) < 30);
            rxpush = ($urandom_range(0, 99) < 35);
            rxd    = 8'($urandom());
            for (int b = 0; b < 5; b++) ev[b] = ($urandom_range(0, 99) < 3);
            step();
        end

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule